// File: doc/BRIEF.md
# Divided-Clock Serial Master

This block is a serial peripheral master for one word at a time. A programmable divider builds the serial clock. The divider takes its input ticks from one of two sources. With the system-clock source, every system clock cycle is a tick. With the external source, only the cycles in which an external enable input is high count as ticks. The external enable is sampled in the system clock domain, so the block uses one clock.

The divide value sets the serial clock period and splits it into a high phase and a low phase. For even divide values the high phase is one tick longer than the low phase.

A client applies a word and the divide value, then pulses `start`. The block then does the following:
- It pulls the active-low select line low.
- It shifts the word out MSB first, changing the data line only at rising serial-clock edges.
- It samples the return line on falling edges.
- After the word, it releases select, stops driving the data line and presents the received word with a one-cycle `done` pulse.

The serial clock rests low between words.

Top module: `spi_clkdiv_master`

## Requirements
- R1: With the effective divide value D even, the serial clock high phase lasts D/2+1 ticks and the low phase lasts D/2 ticks, giving a period of D+1 ticks.
- R2: With D odd, the high and low phases both last (D+1)/2 ticks.
- R3: A divide value of 0 is treated as 1, giving one tick high and one tick low.
- R4: With `src_ext`=0 every system clock cycle is a tick. With `src_ext`=1 only cycles with `ext_en`=1 are ticks. With `ext_en` high every other cycle, each phase lasts twice as many system cycles.
- R5: While idle, `ss_n`=1 and `sclk`=0. `ss_n` falls low-phase-length ticks before the first rising edge, and `sclk` toggles only while `ss_n`=0.
- R6: Transmit data leaves MSB first. `mosi` holds the MSB from the fall of `ss_n`, changes only at rising `sclk` edges and stays stable while `sclk` is high. Each word has exactly WORD_W falling edges.
- R7: `miso` is sampled at each falling `sclk` edge. The first sampled bit becomes bit WORD_W-1 of `rx_data`.
- R8: `ss_n` rises one low-phase length after the last falling edge. In that same cycle `mosi_oe` drops to 0 and `done` pulses for one cycle with `rx_data` valid.
- R9: `busy` is 1 from the cycle after an accepted `start` until `ss_n` rises. A `start` while busy is ignored and does not change the word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_ext | input | 1 | Divider tick source: 0 system clock, 1 external enable |
| ext_en | input | 1 | External tick enable, sampled on clk |
| div | input | DIV_W | Divide value, captured at start |
| start | input | 1 | Begin a word when idle |
| tx_data | input | WORD_W | Word to send, captured at start |
| busy | output | 1 | Transfer in progress |
| rx_data | output | WORD_W | Last received word |
| done | output | 1 | One-cycle pulse at word completion |
| sclk | output | 1 | Serial clock, idle low |
| ss_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for mosi; 0 means high impedance |
| miso | input | 1 | Serial data in |

## Verification
The following hold on every cycle and are checked there:
- the clock stays low while select is high;
- select is low before and at each rising edge;
- `mosi` is stable through each high phase;
- `done` is a lone pulse that arrives with select released and the driver off.

The bench scenarios cover the rest:
- the phase widths for even, odd and zero divide values under both tick sources;
- the lead and tail lengths;
- the MSB-first bit order in both directions;
- a start that arrives while busy and must be ignored.

// File: rtl/spi_clkdiv_master.sv
module spi_clkdiv_master #(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_ext,
  input  logic              ext_en,
  input  logic [DIV_W-1:0]  div,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_data,
  output logic              busy,
  output logic [WORD_W-1:0] rx_data,
  output logic              done,
  output logic              sclk,
  output logic              ss_n,
  output logic              mosi,
  output logic              mosi_oe,
  input  logic              miso
);
  localparam int CNT_W = DIV_W + 1;
  localparam int BIT_W = $clog2(WORD_W + 1);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_HIGH, S_LOW, S_TAIL} state_t;

  state_t             state;
  logic [DIV_W-1:0]   div_q;
  logic [CNT_W-1:0]   cnt;
  logic [BIT_W-1:0]   nbit;
  logic [WORD_W-1:0]  sh_tx, sh_rx;
  logic               src_q;

  logic               tick, last;
  logic [CNT_W-1:0]   half_odd, hi_len, lo_len, len;

  assign tick     = src_q ? ext_en : 1'b1;
  assign half_odd = ({1'b0, div_q} + CNT_W'(1)) >> 1;
  assign hi_len   = div_q[0] ? half_odd : CNT_W'(div_q >> 1) + CNT_W'(1);
  assign lo_len   = div_q[0] ? half_odd : CNT_W'(div_q >> 1);
  assign len      = (state == S_HIGH) ? hi_len : lo_len;
  assign last     = tick && (cnt == len - CNT_W'(1));

  assign busy    = (state != S_IDLE);
  assign ss_n    = (state == S_IDLE);
  assign mosi_oe = (state != S_IDLE);
  assign sclk    = (state == S_HIGH);
  assign mosi    = sh_tx[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      div_q   <= DIV_W'(1);
      src_q   <= 1'b0;
      cnt     <= '0;
      nbit    <= '0;
      sh_tx   <= '0;
      sh_rx   <= '0;
      rx_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          div_q <= (div == '0) ? DIV_W'(1) : div;
          src_q <= src_ext;
          sh_tx <= tx_data;
          cnt   <= '0;
          nbit  <= '0;
          state <= S_LEAD;
        end
      end else if (tick) begin
        if (!last) begin
          cnt <= cnt + CNT_W'(1);
        end else begin
          cnt <= '0;
          unique case (state)
            S_LEAD: state <= S_HIGH;
            S_HIGH: begin
              sh_rx <= {sh_rx[WORD_W-2:0], miso};
              nbit  <= nbit + BIT_W'(1);
              state <= (nbit == BIT_W'(WORD_W - 1)) ? S_TAIL : S_LOW;
            end
            S_LOW: begin
              sh_tx <= {sh_tx[WORD_W-2:0], 1'b0};
              state <= S_HIGH;
            end
            S_TAIL: begin
              rx_data <= sh_rx;
              done    <= 1'b1;
              state   <= S_IDLE;
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> !sclk); // R5
  AST_SS_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (!ss_n && $past(!ss_n))); // R5
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R6
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ss_n && !mosi_oe && !sclk)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
endmodule

// File: tb/tb_spi_clkdiv_master.sv
module tb_spi_clkdiv_master;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic src_ext = 1'b0, ext_en = 1'b0, start = 1'b0, miso;
  logic [7:0] div = 8'd1;
  logic [W-1:0] tx_data = '0, rx_data;
  logic busy, done, sclk, ss_n, mosi, mosi_oe;

  spi_clkdiv_master #(.WORD_W(W), .DIV_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .src_ext(src_ext), .ext_en(ext_en), .div(div),
    .start(start), .tx_data(tx_data), .busy(busy), .rx_data(rx_data),
    .done(done), .sclk(sclk), .ss_n(ss_n), .mosi(mosi), .mosi_oe(mosi_oe),
    .miso(miso));

  always #5 clk = ~clk;
  always @(negedge clk) ext_en <= ~ext_en;

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench-side slave model and monitor
  logic clr = 1'b1;
  logic [W-1:0] pat = '0, got_tx;
  logic p_sclk, p_ss;
  int run, hi_w, lo_w, lead_w, tail_w, nfall, nrise, ndone, midx;

  assign miso = pat[W-1-((midx > W-1) ? W-1 : midx)];

  always @(negedge clk) begin
    if (clr) begin
      run = 0; hi_w = 0; lo_w = 0; lead_w = 0; tail_w = 0;
      nfall = 0; nrise = 0; ndone = 0; midx = 0; got_tx = '0;
    end else begin
      if (!ss_n) begin
        if (p_ss) run = 1;
        else if (sclk && !p_sclk) begin
          if (nrise == 0) lead_w = run; else lo_w = run;
          nrise++;
          if (nrise > 1) midx++;
          run = 1;
        end else if (!sclk && p_sclk) begin
          hi_w = run; got_tx = {got_tx[W-2:0], mosi}; nfall++; run = 1;
        end else run++;
      end else if (!p_ss) tail_w = run;
      if (done) ndone++;
    end
    p_sclk = sclk; p_ss = ss_n;
  end

  function automatic int eff(input int d); return (d == 0) ? 1 : d; endfunction
  function automatic int hi_of(input int d);
    return (eff(d) % 2) ? (eff(d) + 1) / 2 : eff(d) / 2 + 1;
  endfunction
  function automatic int lo_of(input int d);
    return (eff(d) % 2) ? (eff(d) + 1) / 2 : eff(d) / 2;
  endfunction

  task automatic run_word(input int d, input bit ext, input logic [W-1:0] tx,
                          input logic [W-1:0] rxp, input bit busy_poke);
    int sc, guard;
    sc = ext ? 2 : 1;
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0; pat = rxp; div = d[7:0]; src_ext = ext; tx_data = tx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && ss_n === 1'b0, "R9 busy after start", busy, 1);
    chk(mosi === tx[W-1] && mosi_oe === 1'b1, "R6 msb at select", mosi, tx[W-1]);
    if (busy_poke) begin
      repeat (6) @(negedge clk);
      tx_data = ~tx; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (done !== 1'b1 && guard < 5000) begin @(negedge clk); guard++; end
    chk(guard < 5000, "R8 done arrives", guard, 0);
    chk(rx_data === rxp, "R7 received word", rx_data, rxp);
    chk(ss_n === 1'b1 && mosi_oe === 1'b0, "R8 released at done", {ss_n, mosi_oe}, 2'b10);
    @(negedge clk);
    chk(done === 1'b0, "R8 done one cycle", done, 0);
    repeat (4) @(negedge clk);
    chk(ndone == 1 && busy === 1'b0, "R9 single completion", ndone, 1);
    chk(got_tx === tx, "R6 transmitted msb first", got_tx, tx);
    chk(nfall == W, "R6 falling edge count", nfall, W);
    if (eff(d) % 2) chk(hi_w == sc * hi_of(d), "R2 high width", hi_w, sc * hi_of(d));
    else            chk(hi_w == sc * hi_of(d), "R1 high width", hi_w, sc * hi_of(d));
    chk(lo_w == sc * lo_of(d), "R1 R2 low width", lo_w, sc * lo_of(d));
    if (ext) chk(hi_w == 2 * hi_of(d), "R4 external tick scaling", hi_w, 2 * hi_of(d));
    else     chk(lead_w == lo_of(d), "R5 lead length", lead_w, lo_of(d));
    chk(tail_w == sc * lo_of(d), "R8 tail length", tail_w, sc * lo_of(d));
  endtask

  // [24:17] divide, [16] external source, [15:8] tx word, [7:0] miso pattern
  localparam logic [24:0] VEC [8] = '{
    {8'd1, 1'b0, 8'hA5, 8'h3C}, {8'd2, 1'b0, 8'h81, 8'h7E},
    {8'd3, 1'b0, 8'hFF, 8'h00}, {8'd4, 1'b0, 8'h00, 8'hFF},
    {8'd7, 1'b0, 8'h5A, 8'hC3}, {8'd6, 1'b0, 8'h01, 8'h80},
    {8'd2, 1'b1, 8'h96, 8'h69}, {8'd5, 1'b1, 8'hE1, 8'h1E}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(ss_n === 1'b1 && sclk === 1'b0, "R5 reset idle pins", {ss_n, sclk}, 2'b10);
    chk(busy === 1'b0 && done === 1'b0 && mosi_oe === 1'b0, "R9 reset idle", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sclk === 1'b0 && ss_n === 1'b1, "R5 idle after reset", sclk, 0);
    for (int i = 0; i < 8; i++)
      run_word(int'(VEC[i][24:17]), VEC[i][16], VEC[i][15:8], VEC[i][7:0], 1'b0);
    // R3 zero divide behaves as one
    run_word(0, 1'b0, 8'hC6, 8'h39, 1'b0);
    chk(hi_w == 1 && lo_w == 1, "R3 zero divide widths", {hi_w[7:0], lo_w[7:0]}, 16'h0101);
    // R9 start during transfer ignored
    run_word(4, 1'b0, 8'h3A, 8'hA3, 1'b1);
    repeat (10) @(negedge clk);
    chk(ss_n === 1'b1 && sclk === 1'b0, "R9 no restart after poke", ss_n, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule